// File: doc/BRIEF.md
# Boot Strap Preset Sampler and Sequencer

This block runs once after each reset release. It sequences four strap conversions through a shared low-speed ADC port, one strap at a time. Each strap is a resistor-divider voltage that selects one of eight configuration choices. The block turns each 8-bit conversion result into a 3-bit preset and freezes all four presets until the next reset. Any later movement of the strap voltages has no effect.

Once the presets are frozen, the boot strap preset picks a start-up path. Presets 3, 4 and 5 start the noise-reduction application. Each of these three values implies its own talk-distance range, which downstream logic reads from `boot_preset`. Preset 6 starts a bypass mode that plays a 1 kHz test tone. Preset 7 starts a plain passthrough bypass.

The shared band 0–2 selects external boot, which tries sources in a fixed order:

- A serial-flash loader.
- If that fails, a two-wire EEPROM loader.
- If that also fails, the block parks in a state that waits for a host to download code.

Each loader is reached through a start pulse and done/fail inputs. Each attempt is bounded by a cycle timeout.

Top module: `strap_boot_seq`

## Requirements
- R1: With 1 V equal to code 255, a code maps to a preset as follows:
  - codes 166 and up give 0, which stands for the shared band 0–2;
  - 128 to 165 give 3;
  - 92 to 127 give 4;
  - 57 to 91 give 5;
  - 21 to 56 give 6;
  - 0 to 20 give 7.
- R2: A code lying in the voltage gap between two bands takes the preset of the band just below it in voltage. Examples: 163 (about 0.64 V) gives 3, and 19 gives 7.
- R3: Conversions are requested in a fixed order through `adc_sel`: 0 clock select, 1 boot select, 2 channel select, 3 mix ratio select. `adc_req` and `adc_sel` stay steady until a cycle with `adc_valid` high accepts the code.
- R4: In reset and until the fourth code is accepted, `straps_done` and all four preset outputs are 0. One cycle after the fourth acceptance, all of them appear together.
- R5: After `straps_done`, `adc_req` stays low, and `adc_valid` and `adc_code` have no effect. The presets and `straps_done` hold until reset.
- R6: One cycle after `straps_done`, the path is chosen, and exactly one path output is high from then on:
  - boot preset 3, 4 or 5 raises `run_active`;
  - 6 raises `run_tone`;
  - 7 raises `run_pass`.
- R7: Boot preset 0 (the band 0–2) pulses `spi_start` for exactly one cycle, one cycle after `straps_done`.
- R8: While the first loader runs, `spi_done` raises `ext_run` one cycle later and holds it. `spi_fail` instead raises a one-cycle `i2c_start` one cycle later.
- R9: While the second loader runs, `i2c_done` raises `ext_run` one cycle later. `i2c_fail` raises `host_wait`, which then holds until reset.
- R10: A loader that reports nothing for LOADER_TIMEOUT cycles counts as failed. The next start pulse or `host_wait` follows LOADER_TIMEOUT+1 cycles after that loader's start pulse.
- R11: When done and fail of the running loader are high in the same cycle, done wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_req | output | 1 | Conversion request, held until accepted |
| adc_sel | output | 2 | Strap being converted (0 clock, 1 boot, 2 channel, 3 mix) |
| adc_code | input | 8 | Conversion result, 255 = 1 V |
| adc_valid | input | 1 | Result valid; accepted while `adc_req` is high |
| spi_start | output | 1 | One-cycle start of the serial-flash loader |
| spi_done | input | 1 | Serial-flash loader succeeded |
| spi_fail | input | 1 | Serial-flash loader failed |
| i2c_start | output | 1 | One-cycle start of the two-wire EEPROM loader |
| i2c_done | input | 1 | EEPROM loader succeeded |
| i2c_fail | input | 1 | EEPROM loader failed |
| straps_done | output | 1 | All four presets latched |
| clk_preset | output | 3 | Clock select preset |
| boot_preset | output | 3 | Boot select preset |
| chan_preset | output | 3 | Channel select preset |
| mix_preset | output | 3 | Mix ratio preset |
| run_active | output | 1 | Noise-reduction application started |
| run_tone | output | 1 | Test-tone bypass started |
| run_pass | output | 1 | Passthrough bypass started |
| ext_run | output | 1 | Externally loaded code started |
| host_wait | output | 1 | Both loaders failed; waiting for host download |

## Verification
Each result has a fixed delay from the stimulus that causes it:

- A code offered with `adc_valid` is taken at the next rising edge. The next request, or `straps_done` together with the four presets, is visible the cycle after.
- The path output or first start pulse appears one cycle after `straps_done`.
- Loader results appear one cycle after the done or fail input.

The bench changes inputs on falling edges and reads outputs on the falling edge that lies exactly that many rising edges later. For timeouts it counts falling edges from the start pulse to the next start pulse (or `host_wait`) and compares the count with LOADER_TIMEOUT+1.

// File: rtl/strap_boot_pkg.sv
package strap_boot_pkg;

  typedef enum logic [1:0] {SM_RESET, SM_CONV, SM_HOLD} samp_st_e;

  typedef enum logic [1:0] {RT_EXT, RT_ACTIVE, RT_TONE, RT_PASS} route_e;

  typedef enum logic [3:0] {
    BP_IDLE, BP_SPI_GO, BP_SPI_WAIT, BP_I2C_GO, BP_I2C_WAIT,
    BP_HOST, BP_EXT_RUN, BP_ACTIVE, BP_TONE, BP_PASS
  } boot_st_e;

  // Lowest code whose voltage reaches the given millivolt band floor.
  function automatic int unsigned band_floor(input int unsigned mv, input int unsigned code_w);
    int unsigned full;
    full = (32'd1 << code_w) - 32'd1;
    return (mv * full + 32'd999) / 32'd1000;
  endfunction

  // Gap codes fall to the band just below in voltage.
  function automatic logic [2:0] code_to_preset(input logic [15:0] code, input int unsigned code_w);
    int unsigned c;
    c = 32'(code);
    if      (c >= band_floor(32'd650, code_w)) return 3'd0;
    else if (c >= band_floor(32'd500, code_w)) return 3'd3;
    else if (c >= band_floor(32'd360, code_w)) return 3'd4;
    else if (c >= band_floor(32'd220, code_w)) return 3'd5;
    else if (c >= band_floor(32'd80,  code_w)) return 3'd6;
    else                                       return 3'd7;
  endfunction

  function automatic route_e boot_route(input logic [2:0] preset);
    case (preset)
      3'd3, 3'd4, 3'd5: return RT_ACTIVE;
      3'd6:             return RT_TONE;
      3'd7:             return RT_PASS;
      default:          return RT_EXT;
    endcase
  endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_boot_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int N_STRAPS = 4,
  parameter int PRESET_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         adc_req,
  output logic [$clog2(N_STRAPS)-1:0]  adc_sel,
  input  logic [CODE_W-1:0]            adc_code,
  input  logic                         adc_valid,
  output logic                         conv_take,
  output logic                         done,
  output logic [N_STRAPS*PRESET_W-1:0] presets
);
  localparam int SEL_W = $clog2(N_STRAPS);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_STRAPS - 1);

  samp_st_e         st;
  logic [SEL_W-1:0] idx;

  assign adc_req   = (st == SM_CONV);
  assign adc_sel   = idx;
  assign conv_take = adc_req && adc_valid;
  assign done      = (st == SM_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SM_RESET;
      idx <= '0;
    end else begin
      case (st)
        SM_RESET: st <= SM_CONV;
        SM_CONV: if (conv_take) begin
          if (idx == LAST) st <= SM_HOLD;
          else             idx <= idx + 1'b1;
        end
        default: st <= SM_HOLD;
      endcase
    end
  end

  for (genvar g = 0; g < N_STRAPS; g++) begin : g_slot
    logic [PRESET_W-1:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        held <= '0;
      else if (conv_take && idx == SEL_W'(g))
        held <= PRESET_W'(code_to_preset(16'(adc_code), CODE_W));
    end
    assign presets[g*PRESET_W +: PRESET_W] = done ? held : '0;
  end

endmodule

// File: rtl/loader_timer.sv
module loader_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = !clear && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/boot_path_fsm.sv
module boot_path_fsm
  import strap_boot_pkg::*;
#(
  parameter int LOADER_TIMEOUT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       straps_done,
  input  logic [2:0] boot_preset,
  input  logic       spi_done,
  input  logic       spi_fail,
  input  logic       i2c_done,
  input  logic       i2c_fail,
  output logic       spi_start,
  output logic       i2c_start,
  output logic       ext_run,
  output logic       host_wait,
  output logic       run_active,
  output logic       run_tone,
  output logic       run_pass,
  output logic       loader_expired
);
  boot_st_e st, nx;
  logic     waiting;

  assign waiting = (st == BP_SPI_WAIT) || (st == BP_I2C_WAIT);

  loader_timer #(.LIMIT(LOADER_TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!waiting),
    .expired(loader_expired)
  );

  always_comb begin
    nx = st;
    case (st)
      BP_IDLE: if (straps_done) begin
        case (boot_route(boot_preset))
          RT_ACTIVE: nx = BP_ACTIVE;
          RT_TONE:   nx = BP_TONE;
          RT_PASS:   nx = BP_PASS;
          default:   nx = BP_SPI_GO;
        endcase
      end
      BP_SPI_GO:   nx = BP_SPI_WAIT;
      BP_SPI_WAIT: begin
        if (spi_done)                       nx = BP_EXT_RUN;
        else if (spi_fail || loader_expired) nx = BP_I2C_GO;
      end
      BP_I2C_GO:   nx = BP_I2C_WAIT;
      BP_I2C_WAIT: begin
        if (i2c_done)                       nx = BP_EXT_RUN;
        else if (i2c_fail || loader_expired) nx = BP_HOST;
      end
      default:     nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= BP_IDLE;
    else        st <= nx;
  end

  assign spi_start  = (st == BP_SPI_GO);
  assign i2c_start  = (st == BP_I2C_GO);
  assign ext_run    = (st == BP_EXT_RUN);
  assign host_wait  = (st == BP_HOST);
  assign run_active = (st == BP_ACTIVE);
  assign run_tone   = (st == BP_TONE);
  assign run_pass   = (st == BP_PASS);

endmodule

// File: rtl/strap_boot_seq.sv
module strap_boot_seq #(
  parameter int LOADER_TIMEOUT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       adc_req,
  output logic [1:0] adc_sel,
  input  logic [7:0] adc_code,
  input  logic       adc_valid,
  output logic       spi_start,
  input  logic       spi_done,
  input  logic       spi_fail,
  output logic       i2c_start,
  input  logic       i2c_done,
  input  logic       i2c_fail,
  output logic       straps_done,
  output logic [2:0] clk_preset,
  output logic [2:0] boot_preset,
  output logic [2:0] chan_preset,
  output logic [2:0] mix_preset,
  output logic       run_active,
  output logic       run_tone,
  output logic       run_pass,
  output logic       ext_run,
  output logic       host_wait
);
  localparam int CODE_W   = 8;
  localparam int N_STRAPS = 4;
  localparam int PRESET_W = 3;

  logic [N_STRAPS*PRESET_W-1:0] presets;
  logic                         conv_take;
  logic                         loader_expired;

  strap_sampler #(
    .CODE_W  (CODE_W),
    .N_STRAPS(N_STRAPS),
    .PRESET_W(PRESET_W)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_req  (adc_req),
    .adc_sel  (adc_sel),
    .adc_code (adc_code),
    .adc_valid(adc_valid),
    .conv_take(conv_take),
    .done     (straps_done),
    .presets  (presets)
  );

  assign clk_preset  = presets[0*PRESET_W +: PRESET_W];
  assign boot_preset = presets[1*PRESET_W +: PRESET_W];
  assign chan_preset = presets[2*PRESET_W +: PRESET_W];
  assign mix_preset  = presets[3*PRESET_W +: PRESET_W];

  boot_path_fsm #(.LOADER_TIMEOUT(LOADER_TIMEOUT)) u_path (
    .clk           (clk),
    .rst_n         (rst_n),
    .straps_done   (straps_done),
    .boot_preset   (boot_preset),
    .spi_done      (spi_done),
    .spi_fail      (spi_fail),
    .i2c_done      (i2c_done),
    .i2c_fail      (i2c_fail),
    .spi_start     (spi_start),
    .i2c_start     (i2c_start),
    .ext_run       (ext_run),
    .host_wait     (host_wait),
    .run_active    (run_active),
    .run_tone      (run_tone),
    .run_pass      (run_pass),
    .loader_expired(loader_expired)
  );

endmodule

// File: rtl/strap_boot_chk.sv
module strap_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_req,
  input logic [1:0] adc_sel,
  input logic       adc_valid,
  input logic       conv_take,
  input logic       straps_done,
  input logic [2:0] clk_preset,
  input logic [2:0] boot_preset,
  input logic [2:0] chan_preset,
  input logic [2:0] mix_preset,
  input logic       spi_start,
  input logic       i2c_start,
  input logic       ext_run,
  input logic       host_wait,
  input logic       run_active,
  input logic       run_tone,
  input logic       run_pass,
  input logic       loader_expired
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_valid |=> adc_req && $stable(adc_sel));

  // R3
  take_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_take |=> adc_req || straps_done);

  // R4
  presets_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_done |-> (clk_preset == 3'd0 && boot_preset == 3'd0 &&
                      chan_preset == 3'd0 && mix_preset == 3'd0));

  // R5
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    straps_done |-> !adc_req);

  // R5
  presets_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    straps_done |=> straps_done && $stable(clk_preset) && $stable(boot_preset) &&
                    $stable(chan_preset) && $stable(mix_preset));

  // R6
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spi_start, i2c_start, ext_run, host_wait, run_active, run_tone, run_pass}));

  // R6
  active_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> (straps_done && boot_preset >= 3'd3 && boot_preset <= 3'd5));

  // R7
  spi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  // R7
  spi_ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> boot_preset <= 3'd2);

  // R9
  host_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait |=> host_wait);

  // R8
  ext_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_run |=> ext_run);

  // R10
  expiry_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loader_expired |=> (i2c_start || host_wait || ext_run));

endmodule

bind strap_boot_seq strap_boot_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .adc_req       (adc_req),
  .adc_sel       (adc_sel),
  .adc_valid     (adc_valid),
  .conv_take     (conv_take),
  .straps_done   (straps_done),
  .clk_preset    (clk_preset),
  .boot_preset   (boot_preset),
  .chan_preset   (chan_preset),
  .mix_preset    (mix_preset),
  .spi_start     (spi_start),
  .i2c_start     (i2c_start),
  .ext_run       (ext_run),
  .host_wait     (host_wait),
  .run_active    (run_active),
  .run_tone      (run_tone),
  .run_pass      (run_pass),
  .loader_expired(loader_expired)
);

// File: tb/strap_boot_seq_tb.sv
module strap_boot_seq_tb;
  localparam int TMO = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       adc_req, adc_valid = 1'b0;
  logic [1:0] adc_sel;
  logic [7:0] adc_code = 8'd0;
  logic       spi_start, spi_done = 1'b0, spi_fail = 1'b0;
  logic       i2c_start, i2c_done = 1'b0, i2c_fail = 1'b0;
  logic       straps_done, run_active, run_tone, run_pass, ext_run, host_wait;
  logic [2:0] clk_preset, boot_preset, chan_preset, mix_preset;

  strap_boot_seq #(.LOADER_TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .adc_req(adc_req), .adc_sel(adc_sel),
    .adc_code(adc_code), .adc_valid(adc_valid), .spi_start(spi_start),
    .spi_done(spi_done), .spi_fail(spi_fail), .i2c_start(i2c_start),
    .i2c_done(i2c_done), .i2c_fail(i2c_fail), .straps_done(straps_done),
    .clk_preset(clk_preset), .boot_preset(boot_preset), .chan_preset(chan_preset),
    .mix_preset(mix_preset), .run_active(run_active), .run_tone(run_tone),
    .run_pass(run_pass), .ext_run(ext_run), .host_wait(host_wait)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // {code, expected preset}; groups of four feed clock/boot/channel/mix.
  localparam logic [15:0] VEC [16] = '{
    {8'd0,   8'd7}, {8'd17,  8'd7}, {8'd19,  8'd7}, {8'd20,  8'd7},
    {8'd21,  8'd6}, {8'd21,  8'd6}, {8'd56,  8'd6}, {8'd57,  8'd5},
    {8'd91,  8'd5}, {8'd92,  8'd4}, {8'd127, 8'd4}, {8'd128, 8'd3},
    {8'd163, 8'd3}, {8'd166, 8'd0}, {8'd165, 8'd3}, {8'd255, 8'd0}
  };

  function automatic int path_bits();
    return {spi_start, i2c_start, ext_run, host_wait, run_active, run_tone, run_pass};
  endfunction

  task automatic boot(input logic [7:0] c0, input logic [7:0] c1,
                      input logic [7:0] c2, input logic [7:0] c3, input int dly);
    logic [7:0] codes [4];
    codes = '{c0, c1, c2, c3};
    rst_n = 1'b0; adc_valid = 1'b0;
    spi_done = 1'b0; spi_fail = 1'b0; i2c_done = 1'b0; i2c_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      for (int n = 0; n < 20 && !adc_req; n++) @(negedge clk);
      chk("R3 request raised", adc_req, 1);
      chk("R3 strap order", adc_sel, i);
      chk("R4 done low before fourth", straps_done, 0);
      if (dly > 0) begin
        repeat (dly) @(negedge clk);
        chk("R3 request held", adc_req, 1);
        chk("R3 select held", adc_sel, i);
      end
      adc_code = codes[i]; adc_valid = 1'b1;
      @(negedge clk);
      adc_valid = 1'b0;
    end
    chk("R4 done after fourth", straps_done, 1);
  endtask

  // Boot external, then stand in the first loader wait state.
  task automatic to_spi_wait();
    boot(8'd0, 8'd200, 8'd0, 8'd0, 0);
    @(negedge clk);
    chk("R7 spi start pulse", spi_start, 1);
    @(negedge clk);
    chk("R7 spi start single cycle", spi_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // reset state (R4)
    @(negedge clk);
    chk("R4 reset done", straps_done, 0);
    chk("R4 reset req", adc_req, 0);
    chk("R4 reset presets", {clk_preset, boot_preset, chan_preset, mix_preset}, 0);
    chk("R6 reset paths", path_bits(), 0);

    // table walk: R1, R2
    for (int b = 0; b < 4; b++) begin
      boot(VEC[4*b][15:8], VEC[4*b+1][15:8], VEC[4*b+2][15:8], VEC[4*b+3][15:8], 0);
      chk("R1 R2 clock preset", clk_preset,  VEC[4*b][7:0]);
      chk("R1 R2 boot preset",  boot_preset, VEC[4*b+1][7:0]);
      chk("R1 R2 chan preset",  chan_preset, VEC[4*b+2][7:0]);
      chk("R1 R2 mix preset",   mix_preset,  VEC[4*b+3][7:0]);
    end

    // R6 active, with held request (R3) and ignored later conversions (R5)
    boot(8'd10, 8'd100, 8'd140, 8'd250, 3);
    chk("R6 no path yet", path_bits(), 0);
    @(negedge clk);
    chk("R6 active", run_active, 1);
    chk("R6 only active", path_bits(), 1 << 2);
    adc_code = 8'd0; adc_valid = 1'b1;
    repeat (4) @(negedge clk);
    adc_valid = 1'b0;
    chk("R5 req stays low", adc_req, 0);
    chk("R5 presets held", {clk_preset, boot_preset, chan_preset, mix_preset},
        {3'd7, 3'd4, 3'd3, 3'd0});
    chk("R5 done held", straps_done, 1);

    // R6 tone and passthrough
    boot(8'd0, 8'd30, 8'd0, 8'd0, 0);
    @(negedge clk);
    chk("R6 tone", path_bits(), 1 << 1);
    boot(8'd0, 8'd5, 8'd0, 8'd0, 0);
    @(negedge clk);
    chk("R6 passthrough", path_bits(), 1);

    // R8 first loader succeeds
    to_spi_wait();
    spi_done = 1'b1;
    @(negedge clk);
    spi_done = 1'b0;
    chk("R8 ext run after spi done", ext_run, 1);
    repeat (3) @(negedge clk);
    chk("R8 ext run held", path_bits(), 1 << 4);

    // R8 fail -> R9 second loader succeeds
    to_spi_wait();
    spi_fail = 1'b1;
    @(negedge clk);
    spi_fail = 1'b0;
    chk("R8 i2c start after spi fail", i2c_start, 1);
    @(negedge clk);
    chk("R9 i2c start single cycle", i2c_start, 0);
    i2c_done = 1'b1;
    @(negedge clk);
    i2c_done = 1'b0;
    chk("R9 ext run after i2c done", ext_run, 1);

    // R9 both fail
    to_spi_wait();
    spi_fail = 1'b1;
    @(negedge clk);
    spi_fail = 1'b0;
    @(negedge clk);
    i2c_fail = 1'b1;
    @(negedge clk);
    i2c_fail = 1'b0;
    chk("R9 host wait", host_wait, 1);
    repeat (5) @(negedge clk);
    chk("R9 host wait held", path_bits(), 1 << 3);

    // R10 timeouts on both loaders
    boot(8'd0, 8'd255, 8'd0, 8'd0, 0);
    @(negedge clk);
    chk("R7 spi start", spi_start, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!i2c_start && n < 100);
    chk("R10 spi timeout span", n, TMO + 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!host_wait && n < 100);
    chk("R10 i2c timeout span", n, TMO + 1);

    // R11 done beats fail
    to_spi_wait();
    spi_done = 1'b1; spi_fail = 1'b1;
    @(negedge clk);
    spi_done = 1'b0; spi_fail = 1'b0;
    chk("R11 done wins", path_bits(), 1 << 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule